// File: doc/BRIEF.md
# Per-Cycle Thread Issue Selector

This block sits between four per-thread instruction buffers and the single decode slot of a shared, single-issue, in-order pipeline. On every clock it decides which thread context, if any, sends its next instruction. The decision is combinational from the current per-thread status inputs and a small amount of held state. The result is a one-hot select for the thread-select multiplexers, plus a binary index.

A thread can issue only when all of these hold: its instruction buffer holds an instruction, and it is not waiting on a cache miss, a pending trap or interrupt, a long-latency operation, or a shared-resource conflict. It must also not be suspended by power management, and it must not be trying to issue a store into a full store buffer. Among the threads that can issue, the one selected least recently wins. When every thread is ready, this gives a strict rotation.

A thread that has just issued a load stays eligible right away, so a dependent instruction can follow it and pick up bypassed data if the load hits. When a load reported as a miss belongs to a thread with such a speculative load in flight, the block pulses a squash for that thread. It then parks the thread until its miss-return strobe arrives. When nothing can issue, the block drives no select and flags a bubble for decode.

Top module: `thread_issue_sel`

## Requirements
- R1: After reset the recency order, from least to most recently selected, is thread 0, 1, 2, 3, so thread 0 wins the first cycle in which all threads are eligible.
- R2: With all four threads eligible in every cycle, the grants rotate 0, 1, 2, 3, 0, and so on.
- R3: A thread is not selected while its `bufValid` bit is low, or while any of its `longLatBusy`, `missPending`, `trapPending` or `conflict` bits is high. Bit t of every per-thread vector belongs to thread t.
- R4: A thread whose `suspend` bit is high is never selected, whatever its other inputs.
- R5: A high `sbFull` bit blocks its thread only when that thread's `headIsStore` bit is also high. With `headIsStore` low, `sbFull` has no effect on selection.
- R6: Among the eligible threads, the grant goes to the one selected least recently. Every grant makes the granted thread the most recent. With exactly two threads eligible, the grants alternate between them.
- R7: A thread granted while its `headIsLoad` bit is high remains eligible in the following cycle, without waiting for the load's hit or miss report.
- R8: When `ldMiss[t]` is high and thread t has an unresolved speculative load, `squash[t]` is high in that same cycle. Thread t is not selected in that cycle, nor in any later cycle, up to and including the cycle in which `missReturn[t]` is high. It becomes eligible again from the next cycle. An `ldMiss[t]` with no unresolved speculative load gives no squash and changes nothing.
- R9: An `ldHit[t]` resolves thread t's speculative load, so a later `ldMiss[t]` produces no squash.
- R10: When no thread is eligible, `selOneHot` is 0, `selValid` is 0, `selId` is 0 and `bubble` is 1.
- R11: `selOneHot` has at most one bit set. When a thread is selected, `selValid` is 1, `bubble` is 0, and `selId` holds that thread's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bufValid | input | 4 | Thread has an instruction ready in its buffer |
| longLatBusy | input | 4 | Thread has a long-latency instruction in progress |
| missPending | input | 4 | Thread has an outstanding cache miss |
| trapPending | input | 4 | Thread has a trap or interrupt pending |
| conflict | input | 4 | Thread's next instruction hits a resource conflict |
| suspend | input | 4 | Power-management issue suspend |
| sbFull | input | 4 | Thread's private store buffer is full |
| headIsStore | input | 4 | Thread's next instruction is a store |
| headIsLoad | input | 4 | Thread's next instruction is a load |
| ldHit | input | 4 | Hit report for the thread's speculative load |
| ldMiss | input | 4 | Miss report for the thread's speculative load |
| missReturn | input | 4 | Miss data has returned for the thread |
| selOneHot | output | 4 | One-hot thread select |
| selValid | output | 1 | A thread is selected this cycle |
| selId | output | 2 | Index of the selected thread |
| bubble | output | 1 | Inject a no-op into decode |
| squash | output | 4 | Squash the younger instruction of the thread |

## Verification
The bench targets several corner cases, and each one has a typical failure. The first is the same-cycle interaction of a miss report with a grant: a design that checked speculation only on the registered flag would grant the missing thread once more and never squash it. The second is a miss return arriving while the thread is parked: releasing it a cycle early or late would shift every later grant. The third is a store-buffer-full flag with a non-store head, where an over-eager block would stall a thread that has room to issue. Long random runs compare each grant with a recency-order model. They catch an arbiter that falls back to fixed priority or forgets to update recency on a grant, which would starve the higher-numbered threads.

// File: rtl/tis_pkg.sv
package tis_pkg;
  localparam int NTHR  = 4;
  localparam int TID_W = $clog2(NTHR);

  typedef logic [NTHR-1:0] thrVec_t;

  // strobes from the control path to the recency datapath
  typedef struct packed {
    thrVec_t elig;
    logic    anyElig;
  } tisStrobe_t;
endpackage

// File: rtl/tis_ctrl.sv
module tis_ctrl
  import tis_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  thrVec_t    bufValid,
  input  thrVec_t    longLatBusy,
  input  thrVec_t    missPending,
  input  thrVec_t    trapPending,
  input  thrVec_t    conflict,
  input  thrVec_t    suspend,
  input  thrVec_t    sbFull,
  input  thrVec_t    headIsStore,
  input  thrVec_t    headIsLoad,
  input  thrVec_t    ldHit,
  input  thrVec_t    ldMiss,
  input  thrVec_t    missReturn,
  input  thrVec_t    grantVec,
  output tisStrobe_t strobe,
  output thrVec_t    squashVec
);
  thrVec_t specLd;
  thrVec_t parked;
  thrVec_t eligVec;

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      squashVec[t] = ldMiss[t] & specLd[t];
      eligVec[t]   = bufValid[t] & ~longLatBusy[t] & ~missPending[t]
                   & ~trapPending[t] & ~conflict[t] & ~suspend[t]
                   & ~(sbFull[t] & headIsStore[t])
                   & ~parked[t] & ~squashVec[t];
    end
    strobe.elig    = eligVec;
    strobe.anyElig = |eligVec;
  end

  genvar g;
  generate
    for (g = 0; g < NTHR; g++) begin : gThr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          specLd[g] <= 1'b0;
          parked[g] <= 1'b0;
        end else begin
          if (grantVec[g] && headIsLoad[g])
            specLd[g] <= 1'b1;
          else if (ldHit[g] || ldMiss[g])
            specLd[g] <= 1'b0;

          if (squashVec[g])
            parked[g] <= 1'b1;
          else if (missReturn[g])
            parked[g] <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tis_pick.sv
module tis_pick
  import tis_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tisStrobe_t       strobe,
  output thrVec_t          grantVec,
  output logic [TID_W-1:0] grantId
);
  // older[i][j] set: thread i was selected less recently than thread j
  logic [NTHR-1:0][NTHR-1:0] older;

  always_comb begin
    for (int i = 0; i < NTHR; i++) begin
      grantVec[i] = strobe.elig[i];
      for (int j = 0; j < NTHR; j++)
        if (j != i && strobe.elig[j] && !older[i][j])
          grantVec[i] = 1'b0;
    end
    grantId = '0;
    for (int i = 0; i < NTHR; i++)
      if (grantVec[i]) grantId = TID_W'(i);
  end

  genvar gi, gj;
  generate
    for (gi = 0; gi < NTHR; gi++) begin : gRow
      for (gj = 0; gj < NTHR; gj++) begin : gCol
        if (gi != gj) begin : gCell
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN)
              older[gi][gj] <= (gi < gj);
            else if (strobe.anyElig) begin
              if (grantVec[gi])      older[gi][gj] <= 1'b0;
              else if (grantVec[gj]) older[gi][gj] <= 1'b1;
            end
          end
        end else begin : gDiag
          assign older[gi][gj] = 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel
  import tis_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [NTHR-1:0]  bufValid,
  input  logic [NTHR-1:0]  longLatBusy,
  input  logic [NTHR-1:0]  missPending,
  input  logic [NTHR-1:0]  trapPending,
  input  logic [NTHR-1:0]  conflict,
  input  logic [NTHR-1:0]  suspend,
  input  logic [NTHR-1:0]  sbFull,
  input  logic [NTHR-1:0]  headIsStore,
  input  logic [NTHR-1:0]  headIsLoad,
  input  logic [NTHR-1:0]  ldHit,
  input  logic [NTHR-1:0]  ldMiss,
  input  logic [NTHR-1:0]  missReturn,
  output logic [NTHR-1:0]  selOneHot,
  output logic             selValid,
  output logic [TID_W-1:0] selId,
  output logic             bubble,
  output logic [NTHR-1:0]  squash
);
  tisStrobe_t strobe;
  thrVec_t    grantVec;
  thrVec_t    eligVec;

  tis_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .bufValid(bufValid), .longLatBusy(longLatBusy), .missPending(missPending),
    .trapPending(trapPending), .conflict(conflict), .suspend(suspend),
    .sbFull(sbFull), .headIsStore(headIsStore), .headIsLoad(headIsLoad),
    .ldHit(ldHit), .ldMiss(ldMiss), .missReturn(missReturn),
    .grantVec(grantVec), .strobe(strobe), .squashVec(squash)
  );

  tis_pick u_pick (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .grantVec(grantVec), .grantId(selId)
  );

  assign eligVec   = strobe.elig;
  assign selOneHot = grantVec;
  assign selValid  = |grantVec;
  assign bubble    = ~selValid;
endmodule

// File: rtl/tis_chk.sv
module tis_chk
  import tis_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic [NTHR-1:0] eligVec,
  input logic [NTHR-1:0] selOneHot,
  input logic            selValid,
  input logic [NTHR-1:0] squash,
  input logic [NTHR-1:0] suspend
);
  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selOneHot));

  // R10
  no_idle_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eligVec != '0) |-> selValid);

  // R6
  lru_no_repeat_chk: assert property (@(posedge clk) disable iff (!rstN)
    selValid |=> !(((selOneHot & $past(selOneHot)) != '0) && ($countones(eligVec) > 1)));

  genvar t;
  generate
    for (t = 0; t < NTHR; t++) begin : gChk
      // R8
      squash_block_now_chk: assert property (@(posedge clk) disable iff (!rstN)
        squash[t] |-> !selOneHot[t]);
      // R8
      squash_park_chk: assert property (@(posedge clk) disable iff (!rstN)
        squash[t] |=> !selOneHot[t]);
      // R4
      suspend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        suspend[t] |-> !selOneHot[t]);
    end
  endgenerate
endmodule

bind thread_issue_sel tis_chk u_chk (
  .clk(clk), .rstN(rstN), .eligVec(eligVec), .selOneHot(selOneHot),
  .selValid(selValid), .squash(squash), .suspend(suspend)
);

// File: tb/test_thread_issue_sel.sv
`timescale 1ns/1ps
module test_thread_issue_sel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] bufValid, longLatBusy, missPending, trapPending, conflict, suspend;
  logic [3:0] sbFull, headIsStore, headIsLoad, ldHit, ldMiss, missReturn;
  logic [3:0] selOneHot, squash;
  logic       selValid, bubble;
  logic [1:0] selId;

  int checks = 0;
  int fails  = 0;
  int ord[4];
  logic [3:0] mSpec, mParked;

  always #2 clk = ~clk;

  thread_issue_sel i_thread_issue_sel (
    .clk(clk), .rstN(rstN),
    .bufValid(bufValid), .longLatBusy(longLatBusy), .missPending(missPending),
    .trapPending(trapPending), .conflict(conflict), .suspend(suspend),
    .sbFull(sbFull), .headIsStore(headIsStore), .headIsLoad(headIsLoad),
    .ldHit(ldHit), .ldMiss(ldMiss), .missReturn(missReturn),
    .selOneHot(selOneHot), .selValid(selValid), .selId(selId),
    .bubble(bubble), .squash(squash)
  );

  task automatic idle();
    bufValid = '0; longLatBusy = '0; missPending = '0; trapPending = '0;
    conflict = '0; suspend = '0; sbFull = '0; headIsStore = '0;
    headIsLoad = '0; ldHit = '0; ldMiss = '0; missReturn = '0;
  endtask

  function automatic logic [3:0] expElig();
    logic [3:0] e;
    for (int t = 0; t < 4; t++)
      e[t] = bufValid[t] & ~longLatBusy[t] & ~missPending[t] & ~trapPending[t]
           & ~conflict[t] & ~suspend[t] & ~(sbFull[t] & headIsStore[t])
           & ~mParked[t] & ~(ldMiss[t] & mSpec[t]);
    return e;
  endfunction

  function automatic logic [3:0] expPick(input logic [3:0] e);
    for (int k = 0; k < 4; k++)
      if (e[ord[k]]) return 4'(1 << ord[k]);
    return 4'b0;
  endfunction

  function automatic logic [1:0] idOf(input logic [3:0] oh);
    for (int k = 0; k < 4; k++)
      if (oh[k]) return 2'(k);
    return 2'd0;
  endfunction

  task automatic step(input string tag);
    logic [3:0] eSel, eSq;
    #1;
    eSel = expPick(expElig());
    eSq  = ldMiss & mSpec;
    checks++;
    if (selOneHot !== eSel || selValid !== (eSel != 0) || bubble !== (eSel == 0)
        || selId !== idOf(eSel)) begin
      fails++;
      $display("FAIL %s: sel=%b valid=%b bubble=%b id=%0d exp sel=%b valid=%b bubble=%b id=%0d",
               tag, selOneHot, selValid, bubble, selId, eSel, eSel != 0, eSel == 0, idOf(eSel));
    end
    checks++;
    if (squash !== eSq) begin
      fails++;
      $display("FAIL %s: squash=%b exp %b", tag, squash, eSq);
    end
    @(posedge clk);
    for (int t = 0; t < 4; t++) begin
      if (eSel[t] && headIsLoad[t]) mSpec[t] = 1'b1;
      else if (ldHit[t] || ldMiss[t]) mSpec[t] = 1'b0;
      if (eSq[t]) mParked[t] = 1'b1;
      else if (missReturn[t]) mParked[t] = 1'b0;
    end
    if (eSel != 0) begin
      int g, p;
      g = idOf(eSel);
      p = 0;
      for (int k = 0; k < 4; k++) if (ord[k] == g) p = k;
      for (int k = p; k < 3; k++) ord[k] = ord[k+1];
      ord[3] = g;
    end
    @(negedge clk);
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog: run hung, act running exp finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    for (int k = 0; k < 4; k++) ord[k] = k;
    mSpec = '0; mParked = '0;
    repeat (3) @(negedge clk);
    // R10: reset state, nothing eligible
    step("R10 reset idle");
    rstN = 1'b1;
    @(negedge clk);
    step("R10 idle after reset");

    // R1 then R2: rotation from thread 0
    bufValid = 4'hF;
    step("R1 first grant");
    for (int i = 0; i < 8; i++) step("R2 rotation");

    // R6: two ready alternate
    bufValid = 4'b1010;
    for (int i = 0; i < 6; i++) step("R6 two ready");

    // R3: each blocking cause on thread 2 alone
    bufValid = 4'b0100;
    longLatBusy = 4'b0100; step("R3 long latency"); longLatBusy = '0;
    missPending = 4'b0100; step("R3 miss pending"); missPending = '0;
    trapPending = 4'b0100; step("R3 trap");         trapPending = '0;
    conflict    = 4'b0100; step("R3 conflict");     conflict = '0;
    bufValid = '0;         step("R3 buffer empty");
    // R4
    bufValid = 4'b0100; suspend = 4'b0100; step("R4 suspend"); suspend = '0;
    // R5
    sbFull = 4'b0100; headIsStore = 4'b0100; step("R5 full store blocked");
    headIsStore = '0; step("R5 full non-store allowed");
    sbFull = '0;

    // R7 and R8: speculative load then miss on thread 0
    idle(); bufValid = 4'b0001; headIsLoad = 4'b0001;
    step("R7 load issue");
    headIsLoad = '0;
    step("R7 reissue before hit");
    ldMiss = 4'b0001; step("R8 miss squash"); ldMiss = '0;
    step("R8 parked");
    step("R8 parked");
    missReturn = 4'b0001; step("R8 return cycle"); missReturn = '0;
    step("R8 released");
    // R8: miss with no speculative load is ignored
    ldMiss = 4'b0001; step("R8 spurious miss"); ldMiss = '0;
    // R9: hit resolves
    headIsLoad = 4'b0001; step("R9 load issue"); headIsLoad = '0;
    ldHit = 4'b0001; step("R9 hit"); ldHit = '0;
    ldMiss = 4'b0001; step("R9 late miss ignored"); ldMiss = '0;

    // R6, R8, R11: constrained random
    for (int i = 0; i < 4000; i++) begin
      idle();
      for (int t = 0; t < 4; t++) begin
        bufValid[t]    = ($urandom % 8) != 0;
        longLatBusy[t] = ($urandom % 8) == 0;
        missPending[t] = ($urandom % 10) == 0;
        trapPending[t] = ($urandom % 12) == 0;
        conflict[t]    = ($urandom % 10) == 0;
        suspend[t]     = ($urandom % 12) == 0;
        sbFull[t]      = ($urandom % 4) == 0;
        headIsStore[t] = ($urandom % 4) == 0;
        headIsLoad[t]  = !headIsStore[t] && (($urandom % 3) == 0);
        if (mSpec[t] && ($urandom % 3) == 0) begin
          if ($urandom % 2) ldMiss[t] = 1'b1; else ldHit[t] = 1'b1;
        end else if (($urandom % 20) == 0) ldMiss[t] = 1'b1;
        missReturn[t] = mParked[t] && (($urandom % 4) == 0);
      end
      step("R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule